// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between one narrow port (A) and a wide port split into two equal halves (first half and second half). In the A-to-wide direction, two words that arrive on A one after the other are combined and shown together on both halves as a single double-width word. The first half has one more register stage than the second half. That extra stage is what lines up an earlier word with a later one.

In the wide-to-A direction, each half is captured in its own register. A select input then picks which captured half is shown on A. Every storage register has its own active-low load enable. When that enable is high, the register keeps its value.

Both port output enables are active low and registered, so a change of bus direction takes effect on a clock edge. High impedance is represented by a per-port drive flag: when the flag is low, the matching data outputs carry no meaning.

Top module: `bus_exchanger`

## Requirements
- R1: While `rst` is high at a rising edge, every data register clears to zero and both drive flags go low. After that edge, `b1_out`, `b2_out`, `a_out`, `a_drive` and `b_drive` all read 0.
- R2: The first-half path from A has two register stages, and both load when `a1_load_n` is low. A word placed on `a_in` appears on `b1_out` after the second rising edge with `a1_load_n` low. After only the first such edge, `b1_out` has not changed.
- R3: The second-half path from A has one register. A word on `a_in` appears on `b2_out` after a single rising edge with `a2_load_n` low.
- R4: At a rising edge where an A-side load enable is high, its stages keep their content. With `a1_load_n` high, `b1_out` and the internal first stage hold. With `a2_load_n` high, `b2_out` holds.
- R5: Word pairing works as follows. Hold `a1_load_n` low for two edges, with word X before the first edge and word Y before the second. Also hold `a2_load_n` low for the second edge only. The result is `b1_out`=X and `b2_out`=Y after the same edge.
- R6: The first-half capture loads `b1_in` at an edge where `b1_load_n` is low. The second-half capture loads `b2_in` at an edge where `b2_load_n` is low. Each capture holds its value when its enable is high.
- R7: `a_out` shows the first-half capture when `sel` is 1 and the second-half capture when `sel` is 0. It follows `sel` without waiting for a clock edge.
- R8: `a_drive` equals the inverse of `oea_n` as sampled at the previous rising edge. A change on `oea_n` has no effect before that edge.
- R9: `b_drive` equals the inverse of `oeb_n` as sampled at the previous rising edge.
- R10: The two registered enables are independent of each other, so both ports may drive at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a1_load_n | input | 1 | Load enable for both first-half stages, active low |
| a2_load_n | input | 1 | Load enable for the second-half register, active low |
| b1_load_n | input | 1 | Load enable for the first-half capture, active low |
| b2_load_n | input | 1 | Load enable for the second-half capture, active low |
| sel | input | 1 | 1 shows the first-half capture on A, 0 shows the second-half capture |
| oea_n | input | 1 | A output enable, active low, registered |
| oeb_n | input | 1 | Wide port output enable, active low, registered |
| a_in | input | W | Narrow port input data |
| a_out | output | W | Narrow port output data |
| a_drive | output | 1 | A port is driving |
| b1_in | input | W | First-half input data |
| b2_in | input | W | Second-half input data |
| b1_out | output | W | First-half output data |
| b2_out | output | W | Second-half output data |
| b_drive | output | 1 | Wide port is driving |

## Verification
The bench builds the block at its default width `W` of 12. At that width each half can carry a distinct bit pattern, so a word that went into the wrong half, or arrived one edge early or late, gives a visibly different value. Changing the select input and the enables between edges shows which outputs react at once and which wait for a clock edge.

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a1_load_n,
  input  logic         a2_load_n,
  input  logic         b1_load_n,
  input  logic         b2_load_n,
  input  logic         sel,
  input  logic         oea_n,
  input  logic         oeb_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b1_out,
  output logic [W-1:0] b2_out,
  output logic         b_drive
);

  logic [W-1:0] lead_q, first_q, second_q, cap1_q, cap2_q;
  logic         oea_q, oeb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_q   <= '0;
      first_q  <= '0;
      second_q <= '0;
      cap1_q   <= '0;
      cap2_q   <= '0;
      oea_q    <= 1'b1;
      oeb_q    <= 1'b1;
    end else begin
      if (!a1_load_n) begin
        lead_q  <= a_in;
        first_q <= lead_q;
      end
      if (!a2_load_n) second_q <= a_in;
      if (!b1_load_n) cap1_q   <= b1_in;
      if (!b2_load_n) cap2_q   <= b2_in;
      oea_q <= oea_n;
      oeb_q <= oeb_n;
    end
  end

  assign b1_out  = first_q;
  assign b2_out  = second_q;
  assign a_out   = sel ? cap1_q : cap2_q;
  assign a_drive = ~oea_q;
  assign b_drive = ~oeb_q;

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (b1_out == '0 && b2_out == '0 && !a_drive && !b_drive));

  p_two_stage_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(a1_load_n) && !$past(a1_load_n, 2))
      |-> b1_out == $past(a_in, 2));

  p_one_stage_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(a2_load_n)) |-> b2_out == $past(a_in));

  p_hold_first_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a1_load_n)) |-> $stable(b1_out));

  p_hold_second_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a2_load_n)) |-> $stable(b2_out));

  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(b1_load_n) && sel) |-> a_out == $past(b1_in));

  p_drive_a_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> a_drive == !$past(oea_n));

  p_drive_b_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> b_drive == !$past(oeb_n));

endmodule

// File: tb/bus_exchanger_tb.sv
module bus_exchanger_tb;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a1_load_n = 1'b1, a2_load_n = 1'b1, b1_load_n = 1'b1, b2_load_n = 1'b1;
  logic sel = 1'b0, oea_n = 1'b1, oeb_n = 1'b1;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drive, b_drive;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bus_exchanger #(.W(W)) u_dut (
    .clk(clk), .rst(rst),
    .a1_load_n(a1_load_n), .a2_load_n(a2_load_n),
    .b1_load_n(b1_load_n), .b2_load_n(b2_load_n),
    .sel(sel), .oea_n(oea_n), .oeb_n(oeb_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b1_in(b1_in), .b2_in(b2_in), .b1_out(b1_out), .b2_out(b2_out),
    .b_drive(b_drive)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    a_in = 12'hFFF; b1_in = 12'hFFF; b2_in = 12'hFFF;
    a1_load_n = 0; a2_load_n = 0; b1_load_n = 0; b2_load_n = 0;
    oea_n = 0; oeb_n = 0;
    rst = 1;
    repeat (3) step();
    chk("R1 b1_out", b1_out, '0);
    chk("R1 b2_out", b2_out, '0);
    chk("R1 a_out", a_out, '0);
    chk("R1 a_drive", {11'd0, a_drive}, 12'd0);
    chk("R1 b_drive", {11'd0, b_drive}, 12'd0);
    a1_load_n = 1; a2_load_n = 1; b1_load_n = 1; b2_load_n = 1;
    oea_n = 1; oeb_n = 1;
    rst = 0;
    step();
  endtask

  task automatic t_first_path();
    a1_load_n = 0; a_in = 12'h111;
    step();
    chk("R2 after one edge", b1_out, '0);
    a_in = 12'h222;
    step();
    chk("R2 after two edges", b1_out, 12'h111);
    a1_load_n = 1; a_in = 12'h333;
    step();
    chk("R4 first half held", b1_out, 12'h111);
    a1_load_n = 0;
    step();
    chk("R4 first stage held", b1_out, 12'h222);
    a1_load_n = 1;
  endtask

  task automatic t_second_path();
    a2_load_n = 0; a_in = 12'h3A5;
    step();
    chk("R3 one edge", b2_out, 12'h3A5);
    a2_load_n = 1; a_in = 12'hFFF;
    step();
    chk("R4 second half held", b2_out, 12'h3A5);
  endtask

  task automatic t_pair();
    a1_load_n = 0; a_in = 12'hABC;
    step();
    a2_load_n = 0; a_in = 12'hDEF;
    step();
    chk("R5 first half", b1_out, 12'hABC);
    chk("R5 second half", b2_out, 12'hDEF);
    a1_load_n = 1; a2_load_n = 1; a_in = 12'h000;
    step();
    chk("R5 pair kept first", b1_out, 12'hABC);
    chk("R5 pair kept second", b2_out, 12'hDEF);
  endtask

  task automatic t_capture();
    b1_in = 12'h5C3; b2_in = 12'h0F0; b1_load_n = 0; b2_load_n = 0; sel = 1;
    step();
    chk("R6 first capture", a_out, 12'h5C3);
    sel = 0;
    #1;
    chk("R7 sel low without edge", a_out, 12'h0F0);
    b1_load_n = 1; b2_load_n = 1; b1_in = 12'h777; b2_in = 12'h888;
    step();
    chk("R6 second capture held", a_out, 12'h0F0);
    sel = 1;
    #1;
    chk("R7 sel high without edge", a_out, 12'h5C3);
    b2_load_n = 0;
    step();
    sel = 0;
    #1;
    chk("R6 second capture reload", a_out, 12'h888);
    b2_load_n = 1;
  endtask

  task automatic t_enables();
    oea_n = 0;
    #1;
    chk("R8 no change before edge", {11'd0, a_drive}, 12'd0);
    step();
    chk("R8 a drives", {11'd0, a_drive}, 12'd1);
    chk("R9 b still off", {11'd0, b_drive}, 12'd0);
    oeb_n = 0;
    step();
    chk("R10 both drive a", {11'd0, a_drive}, 12'd1);
    chk("R10 both drive b", {11'd0, b_drive}, 12'd1);
    oea_n = 1;
    step();
    chk("R8 a off", {11'd0, a_drive}, 12'd0);
    chk("R9 b kept", {11'd0, b_drive}, 12'd1);
    oeb_n = 1;
    step();
    chk("R9 b off", {11'd0, b_drive}, 12'd0);
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_path();
    t_second_path();
    t_pair();
    t_capture();
    t_enables();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule